// File: doc/BRIEF.md
# Predicated Saturating Vector Shift Unit

This block is a single-stage vector datapath. It takes one packed vector operand, a byte-granular predicate and a 7-bit encoded immediate. It splits the operand into equal signed lanes of 8, 16, 32 or 64 bits. Both the lane width and the left-shift distance are decoded from the immediate. Each active lane is shifted left and clamped to its signed range, so it never wraps. Inactive lanes are returned as they came in. The result goes back to the register that supplied the operand, so the write port of the surrounding register file takes `vec_o` whenever `wr_en_o` is high.

The immediate is supplied as three fields:
- a 2-bit upper size field,
- a 2-bit lower size field,
- a 3-bit low shift field.

The two size fields together form a 4-bit size code, and the highest set bit of that code selects the lane width. A size code of zero is a reserved encoding. For that code the block raises an undefined-encoding flag and suppresses the write. A separate flag reports that at least one active lane was clamped. All results are registered and appear one clock after the request.

Top module: `vsat_shift_unit`

## Requirements
- R1: The size code is {tsz_hi_i, tsz_lo_i}, with tsz_hi_i in bits 3:2 and tsz_lo_i in bits 1:0. The lane width is 8 shifted left by the index of the code's highest set bit: 0001→8, 001x→16, 01xx→32, 1xxx→64.
- R2: When the size code is 0000, undef_o is 1, wr_en_o is 0, sat_o is 0 and vec_o equals the operand unchanged.
- R3: The shift distance is the unsigned 7-bit value {size code, imm_i} minus the lane width, which is always in the range 0 to lane width − 1.
- R4: Each active lane is read as a signed integer and shifted left by the decoded distance. Where the true result fits, it is returned exactly; a shift distance of 0 returns the lane unchanged.
- R5: Each lane that is not active is copied from the operand to vec_o bit for bit.
- R6: Lane e is active when pred_i bit (e × lane width / 8) is 1. Predicate bits for the lane's other bytes have no effect.
- R7: Lane e occupies vec bits [e×W +: W] for lane width W, and there are VLEN/W lanes.
- R8: A result that exceeds the signed range becomes 2^(W−1)−1 if the input was non-negative, or −2^(W−1) if it was negative. sat_o is 1 exactly when at least one active lane was clamped.
- R9: A request with valid_i high at a rising edge sets valid_o, vec_o, undef_o and sat_o at that edge. wr_en_o = valid_o and not undef_o. With valid_i low, valid_o and wr_en_o are 0 after the next edge.
- R10: While rst_ni is low, valid_o, wr_en_o, undef_o, sat_o and vec_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| vec_i | input | VLEN | Packed vector operand |
| pred_i | input | VLEN/8 | Predicate, one bit per operand byte |
| tsz_hi_i | input | 2 | Upper half of the size code |
| tsz_lo_i | input | 2 | Lower half of the size code |
| imm_i | input | 3 | Low bits of the shift immediate |
| valid_o | output | 1 | Result present |
| wr_en_o | output | 1 | Write-back enable for the destination register |
| undef_o | output | 1 | Reserved size code seen |
| sat_o | output | 1 | At least one active lane clamped |
| vec_o | output | VLEN | Result vector |

## Verification
Every result of this unit is due at the same point: at the first rising edge after the request is driven, for vector, both flags and the write enable alike. The driver applies each request on a falling edge and queues its expected item at that moment. The monitor samples just after each rising edge. It therefore finds a queued item exactly when valid_o must be high, and it reports as a timing fault both a missing result and a result that has no queued item. Back-to-back requests and idle gaps are both exercised, so a result delayed or duplicated by one cycle is caught.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_S = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned SHAMT_W   = 6;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned IMM_W     = 3;

  function automatic int unsigned lane_bits(input int unsigned idx);
    return 8 << idx;
  endfunction
endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
  import vsat_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  input  logic [IMM_W-1:0]   imm_i,
  output esz_e               esz_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic               undef_o
);
  localparam int unsigned FULL_W = CODE_W + IMM_W;

  logic [FULL_W-1:0] full;
  logic [FULL_W-1:0] bias;
  logic [FULL_W-1:0] diff;

  always_comb begin
    esz_o   = ESZ_B;
    undef_o = 1'b0;
    unique casez (code_i)
      4'b1???: esz_o = ESZ_D;
      4'b01??: esz_o = ESZ_S;
      4'b001?: esz_o = ESZ_H;
      4'b0001: esz_o = ESZ_B;
      default: undef_o = 1'b1;
    endcase
  end

  assign full    = {code_i, imm_i};
  assign bias    = FULL_W'(8) << esz_o;
  assign diff    = full - bias;
  // diff < lane width, so the top bit is always zero for a defined code
  assign shamt_o = diff[SHAMT_W-1:0];
endmodule

// File: rtl/vsat_lane.sv
module vsat_lane #(
  parameter int unsigned LW      = 8,
  parameter int unsigned SHAMT_W = 6
) (
  input  logic [LW-1:0]      x_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               act_i,
  output logic [LW-1:0]      y_o,
  output logic               sat_o
);
  localparam int unsigned WW = 2 * LW;

  logic          sgn;
  logic [WW-1:0] wide;
  logic          ovf;
  logic [LW-1:0] clamp;

  assign sgn  = x_i[LW-1];
  assign wide = {{LW{sgn}}, x_i} << shamt_i;
  // bits pushed out plus new sign must all repeat the original sign
  assign ovf  = wide[WW-1:LW-1] != {(LW+1){sgn}};

  assign clamp = sgn ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};

  always_comb begin
    if (!act_i)   y_o = x_i;
    else if (ovf) y_o = clamp;
    else          y_o = wide[LW-1:0];
  end

  assign sat_o = act_i & ovf;
endmodule

// File: rtl/vsat_group.sv
module vsat_group #(
  parameter int unsigned VLEN    = 256,
  parameter int unsigned LW      = 8,
  parameter int unsigned SHAMT_W = 6
) (
  input  logic [VLEN-1:0]    vec_i,
  input  logic [VLEN/LW-1:0] act_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [VLEN-1:0]    res_o,
  output logic               sat_o
);
  localparam int unsigned LANES = VLEN / LW;

  logic [LANES-1:0] lane_sat;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    vsat_lane #(
      .LW     (LW),
      .SHAMT_W(SHAMT_W)
    ) u_lane (
      .x_i    (vec_i[e*LW +: LW]),
      .shamt_i(shamt_i),
      .act_i  (act_i[e]),
      .y_o    (res_o[e*LW +: LW]),
      .sat_o  (lane_sat[e])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/vsat_shift_unit.sv
module vsat_shift_unit
  import vsat_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic [1:0]        tsz_hi_i,
  input  logic [1:0]        tsz_lo_i,
  input  logic [2:0]        imm_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic              undef_o,
  output logic              sat_o,
  output logic [VLEN-1:0]   vec_o
);
  localparam int unsigned PLEN = VLEN / 8;

  esz_e                              esz;
  logic [SHAMT_W-1:0]                shamt;
  logic                              undef;
  logic [NUM_SIZES-1:0][VLEN-1:0]    grp_res;
  logic [NUM_SIZES-1:0]              grp_sat;
  logic [VLEN-1:0]                   res_d;
  logic                              sat_d;

  logic              valid_q;
  logic              undef_q;
  logic              sat_q;
  logic [VLEN-1:0]   vec_q;

  vsat_decode u_dec (
    .code_i (CODE_W'({tsz_hi_i, tsz_lo_i})),
    .imm_i  (imm_i),
    .esz_o  (esz),
    .shamt_o(shamt),
    .undef_o(undef)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned LW    = lane_bits(g);
    localparam int unsigned LANES = VLEN / LW;
    localparam int unsigned BPL   = LW / 8;

    logic [LANES-1:0] act;
    // lane activity comes from the predicate bit of its lowest byte
    for (genvar e = 0; e < LANES; e++) begin : g_act
      assign act[e] = pred_i[e*BPL];
    end

    vsat_group #(
      .VLEN   (VLEN),
      .LW     (LW),
      .SHAMT_W(SHAMT_W)
    ) u_grp (
      .vec_i  (vec_i),
      .act_i  (act),
      .shamt_i(shamt),
      .res_o  (grp_res[g]),
      .sat_o  (grp_sat[g])
    );
  end

  always_comb begin
    if (undef) begin
      res_d = vec_i;
      sat_d = 1'b0;
    end else begin
      res_d = grp_res[esz];
      sat_d = grp_sat[esz];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      sat_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        undef_q <= undef;
        sat_q   <= sat_d;
        vec_q   <= res_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign wr_en_o = valid_q & ~undef_q;
  assign undef_o = undef_q;
  assign sat_o   = sat_q;
  assign vec_o   = vec_q;

  if (PLEN * 8 != VLEN || VLEN % 64 != 0) begin : g_bad_vlen
    initial $error("VLEN must be a multiple of 64");
  end
endmodule

// File: rtl/vsat_shift_unit_chk.sv
module vsat_shift_unit_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [VLEN-1:0]   vec_i,
  input logic [VLEN/8-1:0] pred_i,
  input logic [1:0]        tsz_hi_i,
  input logic [1:0]        tsz_lo_i,
  input logic [2:0]        imm_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic              undef_o,
  input logic              sat_o,
  input logic [VLEN-1:0]   vec_o
);
  logic [3:0] code;
  assign code = {tsz_hi_i, tsz_lo_i};

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !wr_en_o); // R2
  AST_UNDEF_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && code == 4'd0 |=> undef_o && !sat_o && vec_o == $past(vec_i)); // R2
  AST_DEFINED_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && code != 4'd0 |=> wr_en_o && !undef_o); // R9
  AST_RESULT_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_en_o); // R9
  AST_NO_ACTIVE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pred_i == '0 |=> vec_o == $past(vec_i)); // R5
  AST_NO_ACTIVE_NO_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pred_i == '0 |=> !sat_o); // R8
  AST_ZERO_SHIFT_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && code == 4'b0001 && imm_i == 3'd0 |=> vec_o == $past(vec_i) && !sat_o); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && !wr_en_o && !undef_o && !sat_o && vec_o == '0); // R10
endmodule

bind vsat_shift_unit vsat_shift_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .vec_i   (vec_i),
  .pred_i  (pred_i),
  .tsz_hi_i(tsz_hi_i),
  .tsz_lo_i(tsz_lo_i),
  .imm_i   (imm_i),
  .valid_o (valid_o),
  .wr_en_o (wr_en_o),
  .undef_o (undef_o),
  .sat_o   (sat_o),
  .vec_o   (vec_o)
);

// File: tb/vsat_shift_unit_test.sv
module vsat_shift_unit_test;
  localparam int unsigned VLEN = 256;
  localparam int unsigned PLEN = VLEN / 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [VLEN-1:0]   vec_i = '0;
  logic [PLEN-1:0]   pred_i = '0;
  logic [1:0]        tsz_hi_i = '0;
  logic [1:0]        tsz_lo_i = '0;
  logic [2:0]        imm_i = '0;
  logic              valid_o;
  logic              wr_en_o;
  logic              undef_o;
  logic              sat_o;
  logic [VLEN-1:0]   vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [VLEN-1:0] vec;
    logic            undef;
    logic            sat;
    string           tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk; // 50 MHz

  vsat_shift_unit #(.VLEN(VLEN)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .vec_i   (vec_i),
    .pred_i  (pred_i),
    .tsz_hi_i(tsz_hi_i),
    .tsz_lo_i(tsz_lo_i),
    .imm_i   (imm_i),
    .valid_o (valid_o),
    .wr_en_o (wr_en_o),
    .undef_o (undef_o),
    .sat_o   (sat_o),
    .vec_o   (vec_o)
  );

  task automatic check(input bit ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent reference with 128-bit signed arithmetic
  function automatic exp_t model(input logic [VLEN-1:0] v, input logic [PLEN-1:0] p,
                                 input logic [3:0] code, input logic [2:0] imm,
                                 input string tag);
    exp_t r;
    int   idx = -1;
    int   esz;
    int   sh;
    r.vec = v;
    r.sat = 1'b0;
    r.tag = tag;
    for (int b = 0; b < 4; b++) if (code[b]) idx = b;
    r.undef = (idx < 0);
    if (idx < 0) return r;
    esz = 8 << idx;
    sh  = int'({code, imm}) - esz;
    for (int e = 0; e < int'(VLEN) / esz; e++) begin
      logic signed [127:0] s;
      logic signed [127:0] mx;
      logic signed [127:0] mn;
      if (!p[e*esz/8]) continue;
      s = '0;
      for (int b = 0; b < esz; b++) s[b] = v[e*esz+b];
      for (int b = esz; b < 128; b++) s[b] = v[e*esz+esz-1];
      s  = s <<< sh;
      mx = (128'sd1 <<< (esz - 1)) - 128'sd1;
      mn = -mx - 128'sd1;
      if (s > mx) begin s = mx; r.sat = 1'b1; end
      else if (s < mn) begin s = mn; r.sat = 1'b1; end
      for (int b = 0; b < esz; b++) r.vec[e*esz+b] = s[b];
    end
    return r;
  endfunction

  task automatic drive(input logic [VLEN-1:0] v, input logic [PLEN-1:0] p,
                       input logic [3:0] code, input logic [2:0] imm, input string tag);
    @(negedge clk);
    valid_i  = 1'b1;
    vec_i    = v;
    pred_i   = p;
    tsz_hi_i = code[3:2];
    tsz_lo_i = code[1:0];
    imm_i    = imm;
    q.push_back(model(v, p, code, imm, tag));
  endtask

  // lane width index and shift distance to encoded fields (R3)
  task automatic drive_sz(input logic [VLEN-1:0] v, input logic [PLEN-1:0] p,
                          input int idx, input int sh, input string tag);
    logic [6:0] full;
    full = 7'((8 << idx) + sh);
    drive(v, p, full[6:3], full[2:0], tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] r;
    for (int i = 0; i < int'(VLEN) / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [VLEN-1:0] fill8(input logic [7:0] b);
    logic [VLEN-1:0] r;
    for (int i = 0; i < int'(VLEN) / 8; i++) r[i*8 +: 8] = b;
    return r;
  endfunction

  // monitor: results due one rising edge after the request (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni) begin
        if (q.size() != 0) begin
          exp_t x;
          x = q.pop_front();
          check(valid_o === 1'b1, {"R9 valid_o ", x.tag}, VLEN'(valid_o), VLEN'(1));
          check(vec_o === x.vec, {"R4 R5 R6 R7 vec_o ", x.tag}, vec_o, x.vec);
          check(undef_o === x.undef, {"R1 R2 undef_o ", x.tag}, VLEN'(undef_o), VLEN'(x.undef));
          check(wr_en_o === !x.undef, {"R2 R9 wr_en_o ", x.tag}, VLEN'(wr_en_o), VLEN'(!x.undef));
          check(sat_o === x.sat, {"R8 sat_o ", x.tag}, VLEN'(sat_o), VLEN'(x.sat));
        end else begin
          check(valid_o === 1'b0 && wr_en_o === 1'b0, "R9 idle valid_o",
                VLEN'(valid_o), VLEN'(0));
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o === 0 && wr_en_o === 0 && undef_o === 0 && sat_o === 0,
          "R10 reset flags", {valid_o, wr_en_o, undef_o, sat_o}, '0);
    check(vec_o === '0, "R10 reset vec_o", vec_o, '0);
    rst_ni = 1'b1;

    // R4 zero shift, every size
    for (int s = 0; s < 4; s++) drive_sz(rnd_vec(), '1, s, 0, "R4 zero shift");
    // R8 explicit clamps on bytes: 0x40<<1 -> 0x7f, 0xbf<<1 -> 0x80
    drive_sz(fill8(8'h40), '1, 0, 1, "R8 pos clamp");
    drive_sz(fill8(8'hbf), '1, 0, 1, "R8 neg clamp");
    drive_sz(fill8(8'h20), '1, 0, 1, "R4 fits");
    // R8 maximum shift, every size
    for (int s = 0; s < 4; s++) drive_sz(rnd_vec(), '1, s, (8 << s) - 1, "R3 max shift");
    drive_sz(fill8(8'h00), '1, 3, 63, "R4 zero value max shift");
    drive_sz(fill8(8'hff), '1, 3, 63, "R4 minus one max shift");
    idle(2);
    // R2 reserved code
    drive(rnd_vec(), '1, 4'd0, 3'd5, "R2 reserved");
    drive(rnd_vec(), '0, 4'd0, 3'd0, "R2 reserved no pred");
    // R6 only non-lowest byte bits set for 32-bit lanes
    drive_sz(fill8(8'h7f), {(PLEN/4){4'b1110}}, 2, 31, "R6 upper pred bits");
    drive_sz(fill8(8'h7f), {(PLEN/4){4'b0001}}, 2, 31, "R6 lowest pred bit");
    // R5 nothing active
    drive_sz(rnd_vec(), '0, 1, 9, "R5 all inactive");
    idle(1);
    // R1 R3 R7 raw codes, random predicates, back to back
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [2:0] m;
      c = 4'($urandom);
      m = 3'($urandom);
      drive(rnd_vec(), PLEN'({$urandom, $urandom}), c, m, "R1 R3 R7 random");
      if (i % 37 == 0) idle(1);
    end
    // small values so lanes mostly fit
    for (int i = 0; i < 100; i++) begin
      logic [VLEN-1:0] v;
      int s;
      v = rnd_vec();
      s = i % 4;
      for (int b = 0; b < int'(VLEN) / 8; b++)
        if ((b % (1 << s)) == (1 << s) - 1) v[b*8 +: 8] = {{5{v[b*8+7]}}, v[b*8 +: 3]};
      drive_sz(v, PLEN'({$urandom, $urandom}), s, $urandom_range(0, 3), "R4 small values");
    end
    idle(4);
    check(q.size() == 0, "R9 queue drained", VLEN'(q.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule